// File: doc/BRIEF.md
# External Interrupt Request Bank

This block looks after six external interrupt pins. Each pin has an 8-bit control register. The register holds a 3-bit priority level, a pending-request flag and an edge-polarity choice. A seventh register holds one both-edges bit per pin, and that bit overrides the polarity choice. Each pin passes through a two-flop synchroniser and then an edge detector. When the selected edge appears, the pin's request flag is set.

Software reaches the registers through a byte-wide bus: address, write strobe, write data, and read data that follows the address combinationally. A set flag stays set until software writes 0 to it. The block drives one priority level and one pending bit per pin towards a downstream arbiter. A pin whose level is zero never shows as pending.

Top module: `xirq_bank`

## Requirements
- R1: Control registers for pins 0..5 sit at byte addresses 0..5. Bits 2:0 of each are the priority level, which reads back as written and appears on `lvl_o[3*i+2:3*i]`.
- R2: Bit 4 of a control register selects the edge: 1 means rising, 0 means falling. A pin change driven between clock edges sets bit 3, the request flag, so that it reads 1 after the third rising clock edge and still reads 0 after the second. The opposite edge leaves the flag at 0.
- R3: A bus write of 0 to bit 3 clears the request flag. A write of 1 to bit 3 leaves the flag unchanged, whether it was 0 or 1.
- R4: Address 6 holds the both-edges register, with bit i for pin i. When bit i is 1, both rising and falling edges on pin i set its flag.
- R5: Bits 7:5 of a control register, bits 7:6 of the both-edges register, and every bit at address 7 read as 0. Writes to them are ignored.
- R6: After reset, all registers read 0 and all pending outputs are 0.
- R7: `pend_o[i]` is 1 exactly when pin i's request flag is 1 and its level is non-zero.
- R8: When an edge and a bus write that clears the same flag meet at the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| bus_addr | input | 3 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| lvl_o | output | 18 | Priority level per pin, 3 bits each |
| pend_o | output | 6 | Pending request per pin |

## Verification
The bench targets the write-one-does-nothing rule. A design that took the written bit literally would raise a request from software, or fail to hold one that is already pending. It also lines up a clearing write with the same clock edge as a detected edge. A design that let the clear win would silently drop that request. It checks the edge that should be ignored in each polarity, and both edges in both-edges mode, so that a swapped polarity sense shows up as a flag in the wrong case. It also sets a flag on a level-0 pin, which catches a pending output that does not apply the mask.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int NUM_SRC_DEF = 6;
    localparam int BYTE_W      = 8;
    localparam int LVL_W       = 3;
    localparam int REQ_POS     = 3;
    localparam int POL_POS     = 4;

    typedef struct packed {
        logic             pol;
        logic             req;
        logic [LVL_W-1:0] lvl;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(ctrl_t c);
        logic [BYTE_W-1:0] b;
        b                = '0;
        b[LVL_W-1:0]     = c.lvl;
        b[REQ_POS]       = c.req;
        b[POL_POS]       = c.pol;
        return b;
    endfunction

endpackage

// File: rtl/xirq_edge.sv
module xirq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic pol,
    input  logic both,
    output logic hit
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              s_now;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        s_now = chain_q[STAGES-1];
        rise  = s_now & ~prev_q;
        fall  = ~s_now & prev_q;
        hit   = (rise & (pol | both)) | (fall & (~pol | both));
    end

endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hit,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_en) begin
                ctrl.lvl <= wdata[LVL_W-1:0];
                ctrl.pol <= wdata[POL_POS];
            end
            if (hit) begin
                ctrl.req <= 1'b1;
            end else if (wr_en && !wdata[REQ_POS]) begin
                ctrl.req <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
    import xirq_pkg::*;
#(
    parameter int NUM_SRC     = NUM_SRC_DEF,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(NUM_SRC + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       pin_i,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_we,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic [NUM_SRC*LVL_W-1:0] lvl_o,
    output logic [NUM_SRC-1:0]       pend_o
);
    localparam logic [AW-1:0] BOTH_ADDR = AW'(NUM_SRC);

    ctrl_t              ctrl_q [NUM_SRC];
    logic [NUM_SRC-1:0] both_q;
    logic [NUM_SRC-1:0] edge_hit;
    logic [NUM_SRC-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            both_q <= '0;
        end else if (bus_we && bus_addr == BOTH_ADDR) begin
            both_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic sel_wr;
        assign sel_wr = bus_we && (bus_addr == AW'(g));

        xirq_edge #(.STAGES(SYNC_STAGES)) edge_i (
            .clk  (clk),
            .rst  (rst),
            .pin  (pin_i[g]),
            .pol  (ctrl_q[g].pol),
            .both (both_q[g]),
            .hit  (edge_hit[g])
        );

        xirq_chan chan_i (
            .clk   (clk),
            .rst   (rst),
            .wr_en (sel_wr),
            .wdata (bus_wdata),
            .hit   (edge_hit[g]),
            .ctrl  (ctrl_q[g])
        );

        assign req_q[g]                 = ctrl_q[g].req;
        assign lvl_o[g*LVL_W +: LVL_W]  = ctrl_q[g].lvl;
        assign pend_o[g]                = ctrl_q[g].req && (ctrl_q[g].lvl != '0);
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == AW'(i)) begin
                bus_rdata = ctrl_to_byte(ctrl_q[i]);
            end
        end
        if (bus_addr == BOTH_ADDR) begin
            bus_rdata[NUM_SRC-1:0] = both_q;
        end
    end

endmodule

// File: rtl/xirq_bank_chk.sv
module xirq_bank_chk #(
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] edge_hit,
    input logic [NUM_SRC-1:0] req_q,
    input logic [NUM_SRC-1:0] pend_o,
    input logic [7:0]         bus_rdata
);
    // R6
    reset_clear_chk: assert property (@(posedge clk) rst |=> (req_q == '0 && pend_o == '0));

    // R5
    high_bits_zero_chk: assert property (@(posedge clk) disable iff (rst) bus_rdata[7:6] == 2'b00);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R2
        set_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
            edge_hit[g] |=> req_q[g]);

        // R3
        no_soft_set_chk: assert property (@(posedge clk) disable iff (rst)
            !edge_hit[g] |=> !$rose(req_q[g]));
    end

endmodule

bind xirq_bank xirq_bank_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .edge_hit  (edge_hit),
    .req_q     (req_q),
    .pend_o    (pend_o),
    .bus_rdata (bus_rdata)
);

// File: tb/xirq_bank_tb_top.sv
`timescale 1ns/1ps
module xirq_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pin_i = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [17:0] lvl_o;
    logic [5:0]  pend_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    xirq_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl_o     (lvl_o),
        .pend_o    (pend_o)
    );

    // monitor: pops one expectation per falling edge and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] got;
            it = exp_q.pop_front();
            case (it.kind)
                0:       got = {24'd0, bus_rdata};
                1:       got = {26'd0, pend_o};
                default: got = {14'd0, lvl_o};
            endcase
            n_chk++;
            if (got !== it.exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        #1;
        bus_we    = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind  = kind;
        it.exp   = e;
        it.tag   = tag;
        exp_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R6 reset values
        for (int a = 0; a < 7; a++) expect_item(0, 3'(a), 32'h00, "R6 reset register");
        expect_item(1, 0, 32'h00, "R6 reset pending");

        // R1 R3 R5: write all ones, flag stays 0, reserved bits dropped
        wr(0, 8'hFF);
        expect_item(0, 0, 32'h17, "R1 R5 ctrl0 readback");
        wr(5, 8'hE0);
        expect_item(0, 5, 32'h00, "R5 ctrl5 reserved ignored");

        // R2 rising edge, timing of flag
        pin_i[0] = 1'b1;
        step(1);
        expect_item(0, 0, 32'h17, "R2 flag not yet after two edges");
        expect_item(0, 0, 32'h1F, "R2 flag after third edge");
        expect_item(1, 0, 32'h01, "R7 pending ch0");

        // R3 clear, R2 falling ignored in rising mode
        wr(0, 8'h17);
        expect_item(0, 0, 32'h17, "R3 write 0 clears");
        pin_i[0] = 1'b0;
        step(5);
        expect_item(0, 0, 32'h17, "R2 falling ignored when rising selected");

        // R2 falling mode
        wr(1, 8'h02);
        pin_i[1] = 1'b1;
        step(5);
        expect_item(0, 1, 32'h02, "R2 rising ignored when falling selected");
        pin_i[1] = 1'b0;
        step(5);
        expect_item(0, 1, 32'h0A, "R2 falling sets flag");
        expect_item(1, 0, 32'h02, "R7 pending ch1");

        // R3 write one keeps, write zero clears
        wr(1, 8'h0A);
        expect_item(0, 1, 32'h0A, "R3 write 1 keeps set flag");
        wr(1, 8'h02);
        expect_item(0, 1, 32'h02, "R3 clear ch1");
        wr(2, 8'h08);
        expect_item(0, 2, 32'h00, "R3 write 1 cannot set flag");

        // R4 both edges
        wr(6, 8'hC4);
        expect_item(0, 6, 32'h04, "R4 R5 both-edges readback");
        wr(2, 8'h03);
        pin_i[2] = 1'b1;
        step(5);
        expect_item(0, 2, 32'h0B, "R4 rising sets in both mode");
        wr(2, 8'h03);
        expect_item(0, 2, 32'h03, "R3 clear ch2");
        pin_i[2] = 1'b0;
        step(5);
        expect_item(0, 2, 32'h0B, "R4 falling sets in both mode");

        // R7 level zero masks pending
        wr(3, 8'h10);
        pin_i[3] = 1'b1;
        step(5);
        expect_item(0, 3, 32'h18, "R2 flag set on level-0 source");
        expect_item(1, 0, 32'h04, "R7 level 0 masks pending");
        wr(3, 8'h19);
        expect_item(0, 3, 32'h19, "R1 level change keeps flag");
        expect_item(1, 0, 32'h0C, "R7 pending after unmask");

        // R8 hardware set wins over simultaneous clear
        wr(4, 8'h14);
        pin_i[4] = 1'b1;
        step(2);
        wr(4, 8'h14);
        expect_item(0, 4, 32'h1C, "R8 set wins over clear");
        wr(4, 8'h14);
        expect_item(0, 4, 32'h14, "R3 later clear works");

        // R1 level outputs
        expect_item(2, 0, {14'd0, 3'd0, 3'd4, 3'd1, 3'd3, 3'd2, 3'd7}, "R1 level outputs");

        // R5 unused address
        wr(7, 8'hFF);
        expect_item(0, 7, 32'h00, "R5 address 7 reads 0");
        expect_item(0, 6, 32'h04, "R5 address 7 write ignored");

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule